// File: doc/BRIEF.md
# Shortfall Episode Statistics Tracker

This block sits beside a frame-based streaming engine and watches one indication per frame: whether the frame was moved normally or could not be serviced because the buffer ran short. It groups consecutive shortfall frames into episodes. For each episode it counts the episode once and tracks how many bytes the episode has lost so far. It also keeps the longest episode length seen since the last statistics reset.

A programmable limit turns a long episode into a timeout. When the running length reaches the limit, the block raises a one-cycle abort and latches an error code taken from the active streaming mode. A shortfall that occurs while streaming is being shut down is usually harmless. A stop request that arrives during an ongoing episode therefore withdraws that episode from the statistics, so the reported figures describe real operation only.

Every update is registered on the rising clock edge, and every output comes straight from a register.

Top module: `shortfall_stats`

## Requirements
- R1: After a synchronous reset, `episode_cnt`, `longest_len`, `err_code` and `abort` are all zero.
- R2: A shortfall frame (`frame_vld`=1, `frame_short`=1) that arrives when no episode is ongoing starts a new episode. It increments `episode_cnt` by one and saves the present `longest_len` as a backup.
- R3: Each shortfall frame adds FRAME_BYTES (32) to the running episode length. Whenever the new length is greater than or equal to `longest_len`, `longest_len` takes the new length. The length saturates at the all-ones value instead of wrapping.
- R4: A successful frame (`frame_vld`=1, `frame_short`=0) ends the ongoing episode by setting the running length to zero. The next shortfall frame then starts a new episode.
- R5: A `limit_in` of zero disables the timeout, so `abort` never rises.
- R6: When `limit_in` is nonzero and a shortfall frame brings the running length to a value greater than or equal to `limit_in`, `abort` is high for exactly the next cycle. In the same update, `err_code` becomes `mode_in` shifted right by one bit (mode 2 gives 1, mode 4 gives 2) and the running length is cleared, which ends the episode. `err_code` then holds its value until a reset, a statistics clear, or another timeout.
- R7: A `stop_req` while an episode is ongoing restores `longest_len` from the backup, decrements `episode_cnt` by one and ends the episode.
- R8: A `stop_req` with no episode ongoing leaves `episode_cnt` and `longest_len` unchanged.
- R9: `stats_clr` zeroes the count, the longest length, the backup, the running length and the error code in one cycle. It takes priority over `stop_req` and over frame updates in the same cycle.
- R10: `episode_cnt` saturates at its all-ones value instead of wrapping to zero.
- R11: In a cycle with `frame_vld`, `stop_req` and `stats_clr` all low, no statistic changes and `abort` is low in the following cycle.
- R12: When `stop_req` and `frame_vld` are high in the same cycle, the frame is ignored and only the stop takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_vld | input | 1 | One-cycle strobe per frame |
| frame_short | input | 1 | The strobed frame was a shortfall |
| mode_in | input | MODE_W (3) | Active streaming mode code |
| limit_in | input | STAT_W (32) | Timeout limit in bytes; 0 disables the timeout |
| stop_req | input | 1 | Streaming stop request |
| stats_clr | input | 1 | Clear all statistics |
| episode_cnt | output | STAT_W (32) | Number of shortfall episodes |
| longest_len | output | STAT_W (32) | Longest episode length in bytes |
| err_code | output | MODE_W-1 (2) | Timeout error code; 0 means no error |
| abort | output | 1 | One-cycle pulse on a timeout |

## Verification
A backup register holding a stale value stays hidden until a stop request arrives during an episode. It then shows up in `longest_len` one cycle after that stop, so the bench takes longest values up, withdraws episodes and compares the result. A running length that is not cleared by a good frame or a timeout shows up at the next shortfall frame. The count then fails to step, or an unexpected rollback happens on the next stop. Every output is compared with a reference model one cycle after each input change, so any divergence is reported within a single frame of its cause.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  // update selected for one clock, in priority order
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_UNDO  = 3'd2,
    OP_GOOD  = 3'd3,
    OP_SHORT = 3'd4
  } sfs_op_e;
endpackage

// File: rtl/sfs_episode.sv
module sfs_episode
  import sfs_pkg::*;
#(
  parameter int STAT_W      = 32,
  parameter int FRAME_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sfs_op_e           op,
  input  logic              kill,
  input  logic [STAT_W-1:0] longest_q,
  output logic [STAT_W-1:0] len_q,
  output logic [STAT_W-1:0] len_nxt,
  output logic              active,
  output logic [STAT_W-1:0] cnt_q,
  output logic [STAT_W-1:0] bak_q
);
  localparam logic [STAT_W-1:0] STEP = STAT_W'(FRAME_BYTES);
  localparam logic [STAT_W-1:0] TOP  = '1;

  logic [STAT_W:0] len_sum;

  always_comb begin
    len_sum = {1'b0, len_q} + {1'b0, STEP};
    len_nxt = len_sum[STAT_W] ? TOP : len_sum[STAT_W-1:0];
  end

  assign active = (len_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
      cnt_q <= '0;
      bak_q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: begin
          len_q <= '0;
          cnt_q <= '0;
          bak_q <= '0;
        end
        OP_UNDO: begin
          len_q <= '0;
          cnt_q <= cnt_q - STAT_W'(1);
        end
        OP_GOOD: len_q <= '0;
        OP_SHORT: begin
          len_q <= kill ? '0 : len_nxt;
          if (!active) begin
            bak_q <= longest_q;
            if (cnt_q != TOP) cnt_q <= cnt_q + STAT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sfs_peak.sv
module sfs_peak
  import sfs_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sfs_op_e           op,
  input  logic [STAT_W-1:0] len_nxt,
  input  logic [STAT_W-1:0] bak_q,
  output logic [STAT_W-1:0] longest_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      longest_q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: longest_q <= '0;
        OP_UNDO:  longest_q <= bak_q;
        OP_SHORT: if (len_nxt >= longest_q) longest_q <= len_nxt;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sfs_timeout.sv
module sfs_timeout
  import sfs_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  sfs_op_e           op,
  input  logic [STAT_W-1:0] len_nxt,
  input  logic [STAT_W-1:0] limit,
  input  logic [MODE_W-1:0] mode,
  output logic              fire,
  output logic              abort_q,
  output logic [MODE_W-2:0] err_q
);
  assign fire = (op == OP_SHORT) && (limit != '0) && (len_nxt >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      abort_q <= 1'b0;
      err_q   <= '0;
    end else if (op == OP_CLEAR) begin
      abort_q <= 1'b0;
      err_q   <= '0;
    end else begin
      abort_q <= fire;
      if (fire) err_q <= mode[MODE_W-1:1];
    end
  end
endmodule

// File: rtl/shortfall_stats.sv
module shortfall_stats
  import sfs_pkg::*;
#(
  parameter int STAT_W      = 32,
  parameter int MODE_W      = 3,
  parameter int FRAME_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_vld,
  input  logic              frame_short,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [STAT_W-1:0] limit_in,
  input  logic              stop_req,
  input  logic              stats_clr,
  output logic [STAT_W-1:0] episode_cnt,
  output logic [STAT_W-1:0] longest_len,
  output logic [MODE_W-2:0] err_code,
  output logic              abort
);
  sfs_op_e           op;
  logic              active;
  logic              fire;
  logic [STAT_W-1:0] len_q;
  logic [STAT_W-1:0] len_nxt;
  logic [STAT_W-1:0] bak_q;

  always_comb begin
    if (stats_clr)                  op = OP_CLEAR;
    else if (stop_req)              op = active ? OP_UNDO : OP_HOLD;
    else if (frame_vld && frame_short) op = OP_SHORT;
    else if (frame_vld)             op = OP_GOOD;
    else                            op = OP_HOLD;
  end

  sfs_episode #(.STAT_W(STAT_W), .FRAME_BYTES(FRAME_BYTES)) u_ep (
    .clk(clk), .rst(rst), .op(op), .kill(fire), .longest_q(longest_len),
    .len_q(len_q), .len_nxt(len_nxt), .active(active),
    .cnt_q(episode_cnt), .bak_q(bak_q)
  );

  sfs_peak #(.STAT_W(STAT_W)) u_pk (
    .clk(clk), .rst(rst), .op(op), .len_nxt(len_nxt), .bak_q(bak_q),
    .longest_q(longest_len)
  );

  sfs_timeout #(.STAT_W(STAT_W), .MODE_W(MODE_W)) u_to (
    .clk(clk), .rst(rst), .op(op), .len_nxt(len_nxt), .limit(limit_in),
    .mode(mode_in), .fire(fire), .abort_q(abort), .err_q(err_code)
  );
endmodule

// File: rtl/sfs_chk.sv
module sfs_chk #(
  parameter int STAT_W = 32,
  parameter int MODE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_vld,
  input logic              stop_req,
  input logic              stats_clr,
  input logic [MODE_W-1:0] mode_in,
  input logic [STAT_W-1:0] limit_in,
  input logic [STAT_W-1:0] episode_cnt,
  input logic [STAT_W-1:0] longest_len,
  input logic [MODE_W-2:0] err_code,
  input logic              abort
);
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    stats_clr |=> (episode_cnt == '0 && longest_len == '0 && err_code == '0 && !abort));

  // R6
  err_map_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> err_code == $past(mode_in[MODE_W-1:1]));

  // R5
  no_limit_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> $past(limit_in) != '0);

  // R3
  peak_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (!stats_clr && !stop_req) |=> longest_len >= $past(longest_len));

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!stats_clr && !stop_req) |=>
      (episode_cnt == $past(episode_cnt) || episode_cnt == $past(episode_cnt) + STAT_W'(1)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_vld && !stop_req && !stats_clr) |=>
      ($stable(episode_cnt) && $stable(longest_len) && !abort));
endmodule

bind shortfall_stats sfs_chk #(.STAT_W(STAT_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst(rst), .frame_vld(frame_vld), .stop_req(stop_req),
  .stats_clr(stats_clr), .mode_in(mode_in), .limit_in(limit_in),
  .episode_cnt(episode_cnt), .longest_len(longest_len),
  .err_code(err_code), .abort(abort)
);

// File: tb/sim_shortfall_stats.sv
`timescale 1ns/1ps
module sim_shortfall_stats;
  localparam int BW = 10;
  localparam int MW = 3;
  localparam int TOPV = (1 << BW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_vld = 1'b0;
  logic          frame_short = 1'b0;
  logic [MW-1:0] mode_in = '0;
  logic [BW-1:0] limit_in = '0;
  logic          stop_req = 1'b0;
  logic          stats_clr = 1'b0;
  logic [BW-1:0] episode_cnt;
  logic [BW-1:0] longest_len;
  logic [MW-2:0] err_code;
  logic          abort;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cnt, m_long, m_bak, m_len, m_err;
  bit m_abort;

  always #10 clk = ~clk;

  shortfall_stats #(.STAT_W(BW), .MODE_W(MW), .FRAME_BYTES(32)) u0 (
    .clk(clk), .rst(rst), .frame_vld(frame_vld), .frame_short(frame_short),
    .mode_in(mode_in), .limit_in(limit_in), .stop_req(stop_req),
    .stats_clr(stats_clr), .episode_cnt(episode_cnt), .longest_len(longest_len),
    .err_code(err_code), .abort(abort)
  );

  function automatic int sat(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  task automatic model_step();
    int nl;
    m_abort = 0;
    if (stats_clr) begin
      m_cnt = 0; m_long = 0; m_bak = 0; m_len = 0; m_err = 0;
    end else if (stop_req) begin
      if (m_len != 0) begin
        m_long = m_bak; m_cnt = m_cnt - 1; m_len = 0;
      end
    end else if (frame_vld) begin
      if (!frame_short) m_len = 0;
      else begin
        nl = sat(m_len + 32);
        if (m_len == 0) begin
          m_cnt = sat(m_cnt + 1); m_bak = m_long;
        end
        if (nl >= m_long) m_long = nl;
        if (limit_in != 0 && nl >= int'(limit_in)) begin
          m_abort = 1; m_err = int'(mode_in) >> 1; m_len = 0;
        end else m_len = nl;
      end
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmp_all(input string req);
    chk(req, "episode_cnt", int'(episode_cnt), m_cnt);
    chk(req, "longest_len", int'(longest_len), m_long);
    chk(req, "err_code", int'(err_code), m_err);
    chk(req, "abort", int'(abort), int'(m_abort));
  endtask

  // apply inputs for one clock, advance model, compare after the edge
  task automatic cyc(input string req, input bit v, input bit s, input bit st, input bit cl);
    frame_vld = v; frame_short = s; stop_req = st; stats_clr = cl;
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all(req);
    frame_vld = 0; frame_short = 0; stop_req = 0; stats_clr = 0;
  endtask

  initial begin
    m_cnt = 0; m_long = 0; m_bak = 0; m_len = 0; m_err = 0; m_abort = 0;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    cmp_all("R1");

    // R2 R3: episode of three frames
    mode_in = 3'd2; limit_in = '0;
    cyc("R2", 1, 1, 0, 0);
    cyc("R3", 1, 1, 0, 0);
    cyc("R3", 1, 1, 0, 0);
    chk("R3", "longest after 3", int'(longest_len), 96);
    chk("R2", "count after 3", int'(episode_cnt), 1);
    // R11 idle cycle
    cyc("R11", 0, 1, 0, 0);
    // R4 good frame ends episode, next short starts new one
    cyc("R4", 1, 0, 0, 0);
    cyc("R4", 1, 1, 0, 0);
    chk("R4", "count new episode", int'(episode_cnt), 2);
    chk("R4", "longest kept", int'(longest_len), 96);
    // R7 grow past longest, then stop rolls back
    repeat (3) cyc("R3", 1, 1, 0, 0);
    chk("R3", "longest grown", int'(longest_len), 128);
    cyc("R7", 0, 0, 1, 0);
    chk("R7", "longest restored", int'(longest_len), 96);
    chk("R7", "count decremented", int'(episode_cnt), 1);
    // R8 stop without episode
    cyc("R8", 0, 0, 1, 0);
    chk("R8", "count unchanged", int'(episode_cnt), 1);
    chk("R8", "longest unchanged", int'(longest_len), 96);
    // R12 stop with frame in same cycle: frame ignored
    cyc("R12", 1, 1, 1, 0);
    chk("R12", "count", int'(episode_cnt), 1);
    // R5 limit zero: long episode, no abort
    repeat (12) cyc("R5", 1, 1, 0, 0);
    chk("R5", "abort low", int'(abort), 0);
    cyc("R4", 1, 0, 0, 0);
    // R6 timeout in receive mode
    limit_in = 10'd64; mode_in = 3'd2;
    cyc("R6", 1, 1, 0, 0);
    chk("R6", "no abort below limit", int'(abort), 0);
    cyc("R6", 1, 1, 0, 0);
    chk("R6", "abort at limit", int'(abort), 1);
    chk("R6", "err rx", int'(err_code), 1);
    cyc("R6", 0, 0, 0, 0);
    chk("R6", "abort one cycle", int'(abort), 0);
    chk("R6", "err held", int'(err_code), 1);
    // R6 episode ended by timeout: stop does not roll back
    cyc("R6", 0, 0, 1, 0);
    chk("R6", "no rollback after timeout", int'(episode_cnt), 3);
    // R6 transmit-run mode
    mode_in = 3'd4;
    cyc("R6", 1, 1, 0, 0);
    cyc("R6", 1, 1, 0, 0);
    chk("R6", "err tx", int'(err_code), 2);
    // R9 clear beats frame and stop
    cyc("R9", 1, 1, 1, 1);
    chk("R9", "count", int'(episode_cnt), 0);
    chk("R9", "longest", int'(longest_len), 0);
    chk("R9", "err", int'(err_code), 0);
    // R3 length saturation
    limit_in = '0;
    repeat (34) cyc("R3", 1, 1, 0, 0);
    chk("R3", "length saturates", int'(longest_len), TOPV);
    cyc("R9", 0, 0, 0, 1);

    // random mix (R11 and all others via model)
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 3);
      limit_in = (r == 0) ? 10'd0 : (r == 1) ? 10'd64 : (r == 2) ? 10'd160 : 10'd320;
      mode_in = MW'($urandom_range(0, 4));
      cyc("R11", $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
          $urandom_range(0, 29) == 0, $urandom_range(0, 199) == 0);
    end

    // R10 count saturation
    limit_in = '0;
    cyc("R10", 0, 0, 0, 1);
    for (int i = 0; i < 1030; i++) begin
      cyc("R10", 1, 1, 0, 0);
      cyc("R10", 1, 0, 0, 0);
    end
    chk("R10", "count saturated", int'(episode_cnt), TOPV);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule